// File: doc/BRIEF.md
# Double-Buffered PWM Generator with Sticky Completion Flag

This block produces one pulse-width-modulated output from a 16-bit counter. Software places a period and a high-time into two front registers over a simple register port. The running waveform uses a separate pair of working registers. These are refreshed from the front pair only at a period boundary, when the channel is enabled, or when software issues a load command. Because of this, a new setting never cuts a period short and never produces a runt pulse.

A completion flag is set by hardware each time the working registers are refreshed. It stays set until software clears it. To clear it, software must first read the status register while the flag is one, and then write that bit as zero. If a new refresh happens between that read and that write, the clear is dropped.

A 3-bit level field turns the flag into an interrupt request. The status register also shows the live output level. It holds a load control bit that always reads back as zero.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset, pwm_o and irq_o are 0, irq_lvl_o is 0, and every register reads 0.
- R2: reg_sel_i selects the register: 0 is status, 1 is period front, 2 is pulse front, and 3 reads 0. The period and pulse front registers read back what was written. The status word has the flag at bit 15, the level at bits 14:12, the pin level at bit 7, and the load bit at bit 5. Every other status bit reads 0.
- R3: On the first clock edge with en_i high, the working pair is copied from the front pair and the counter restarts at 1. The flag is set. pwm_o goes high if and only if the working pulse value is nonzero.
- R4: With period P (P >= 1) and pulse W, pwm_o is high for the first W cycles of every P-cycle period. W = 0 gives a constant low output. W >= P gives a constant high output.
- R5: Writes to the front registers do not change the current period. The new values apply from the next period boundary, and that boundary sets the flag.
- R6: Once set, the flag stays set through later boundaries until software clears it.
- R7: The flag clears only when a status read that returned flag = 1 is followed by a status write with bit 15 = 0. A write of bit 15 = 1 has no effect. A write of zero without a qualifying read has no effect.
- R8: If a boundary or a load occurs between the qualifying read and the zero write, the flag is not cleared.
- R9: While en_i is low, pwm_o is 0 and the flag is held at 0. Load commands are ignored.
- R10: Writing status with bit 5 = 1 while enabled reloads the working pair, restarts the counter at 1, sets the flag, and drives pwm_o high if and only if the new pulse value is nonzero. Bit 5 always reads 0.
- R11: irq_o is high exactly when the flag is 1 and the level is nonzero. irq_lvl_o carries the level while irq_o is high and is 0 otherwise.
- R12: The pin bit (bit 7) always matches pwm_o. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| reg_sel_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (arms the flag clear) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |
| irq_lvl_o | output | 3 | Level of the active request |
| pwm_o | output | 1 | PWM output |

## Verification
A corrupted counter or working register shows on pwm_o within one period. The high time or the boundary moves by at least one cycle, and the cycle-by-cycle comparison catches that. A wrong flag or a wrong arm state is visible in the next cycle on irq_o and on status bit 15. The arm state itself only shows when the following zero write either clears the flag or fails to. For that reason the bench places reads and writes on both sides of a boundary.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_PER  = 2'd1,
    SEL_PW   = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  localparam int PIN_BIT  = 7;
  localparam int LOAD_BIT = 5;
  localparam int N_FRONT  = 2;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int W  = 16,
  parameter int LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          flag_i,
  input  logic          pin_i,
  output logic [W-1:0]  per_f_o,
  output logic [W-1:0]  pw_f_o,
  output logic [LW-1:0] lvl_o,
  output logic          load_o,
  output logic          stat_wr_o,
  output logic          stat_rd_o,
  output logic          flag_wbit_o,
  output logic [W-1:0]  rdata_o
);
  localparam int FLAG_BIT = W - 1;
  localparam int LVL_HI   = FLAG_BIT - 1;

  logic [W-1:0]  front_q [N_FRONT];
  logic [LW-1:0] lvl_q;

  // front registers: index 0 = period, 1 = pulse
  for (genvar g = 0; g < N_FRONT; g++) begin : g_front
    localparam logic [1:0] ADDR = 2'(int'(SEL_PER) + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      front_q[g] <= '0;
      else if (wr_i && sel_i == ADDR)   front_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        lvl_q <= '0;
    else if (wr_i && sel_i == SEL_STAT) lvl_q <= wdata_i[LVL_HI -: LW];
  end

  assign stat_wr_o   = wr_i && (sel_i == SEL_STAT);
  assign stat_rd_o   = rd_i && (sel_i == SEL_STAT);
  assign flag_wbit_o = wdata_i[FLAG_BIT];
  assign load_o      = stat_wr_o && wdata_i[LOAD_BIT] && en_i;
  assign per_f_o     = front_q[0];
  assign pw_f_o      = front_q[1];
  assign lvl_o       = lvl_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_STAT: begin
        rdata_o[FLAG_BIT]         = flag_i;
        rdata_o[LVL_HI -: LW]     = lvl_q;
        rdata_o[PIN_BIT]          = pin_i;
      end
      SEL_PER:  rdata_o = front_q[0];
      SEL_PW:   rdata_o = front_q[1];
      default:  rdata_o = '0;
    endcase
  end

  assert_lvl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_i == SEL_STAT) |=> $stable(lvl_o));
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] per_f_i,
  input  logic [W-1:0] pw_f_i,
  output logic         pwm_o,
  output logic         set_evt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         run_q, out_q;
  logic [W-1:0] cnt_q, per_w_q, pw_w_q;
  logic         restart, wrap;

  assign restart = en_i && (!run_q || load_i);
  assign wrap    = en_i && run_q && !load_i && (cnt_q == per_w_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      out_q   <= 1'b0;
      cnt_q   <= '0;
      per_w_q <= '0;
      pw_w_q  <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (restart || wrap) begin
      run_q   <= 1'b1;
      per_w_q <= per_f_i;
      pw_w_q  <= pw_f_i;
      cnt_q   <= ONE;
      out_q   <= |pw_f_i;
    end else begin
      cnt_q <= cnt_q + ONE;
      if (cnt_q == pw_w_q) out_q <= 1'b0;
    end
  end

  assign pwm_o     = out_q;
  assign set_evt_o = restart || wrap;

  assert_restart_cnt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (!run_q || load_i)) |=> (cnt_q == ONE && run_q));

  assert_off_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && per_w_q != '0) |-> (cnt_q >= ONE && cnt_q <= per_w_q));

  assert_zero_pulse_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !load_i && pw_w_q == '0 && cnt_q != per_w_q) |=> !pwm_o);
endmodule

// File: rtl/pwm_flag.sv
module pwm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_evt_i,
  input  logic stat_rd_i,
  input  logic stat_wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_evt_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;          // a new event cancels a pending clear
    end else if (stat_wr_i) begin
      if (armed_q && !wbit_i) flag_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (stat_rd_i) begin
      armed_q <= flag_q;
    end
  end

  assign flag_o = flag_q;

  assert_set_evt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && set_evt_i) |=> flag_o);

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && flag_o && !(stat_wr_i && !wbit_i)) |=> flag_o);

  assert_no_self_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_evt_i) |=> !flag_o);

  assert_off_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !flag_o);
endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
  parameter int W  = 16,
  parameter int LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    reg_sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          irq_o,
  output logic [LW-1:0] irq_lvl_o,
  output logic          pwm_o
);
  logic [W-1:0]  per_f, pw_f;
  logic [LW-1:0] lvl;
  logic          load, stat_wr, stat_rd, wbit, flag, set_evt, pwm;

  pwm_regs #(.W(W), .LW(LW)) u_regs (
    .clk_i, .rst_ni, .en_i,
    .sel_i(reg_sel_i), .wr_i, .rd_i, .wdata_i,
    .flag_i(flag), .pin_i(pwm),
    .per_f_o(per_f), .pw_f_o(pw_f), .lvl_o(lvl),
    .load_o(load), .stat_wr_o(stat_wr), .stat_rd_o(stat_rd),
    .flag_wbit_o(wbit), .rdata_o
  );

  pwm_core #(.W(W)) u_core (
    .clk_i, .rst_ni, .en_i,
    .load_i(load), .per_f_i(per_f), .pw_f_i(pw_f),
    .pwm_o(pwm), .set_evt_o(set_evt)
  );

  pwm_flag u_flag (
    .clk_i, .rst_ni, .en_i,
    .set_evt_i(set_evt), .stat_rd_i(stat_rd), .stat_wr_i(stat_wr),
    .wbit_i(wbit), .flag_o(flag)
  );

  assign pwm_o     = pwm;
  assign irq_o     = flag && (lvl != '0);
  assign irq_lvl_o = irq_o ? lvl : '0;

  assert_irq_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);
endmodule

// File: tb/pwm_dbuf_tb_top.sv
`timescale 1ns/1ps
module pwm_dbuf_tb_top;
  typedef struct {
    logic        pwm;
    logic        irq;
    logic [2:0]  lvl;
    logic [15:0] rdata;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        irq, pwm;
  logic [2:0]  irq_lvl;

  int n_chk = 0, n_err = 0;
  item_t sb_q[$];

  // reference state
  bit          m_run = 0, m_fl = 0, m_arm = 0;
  int          m_p = 0;
  int          m_cper = 0, m_cpw = 0, m_fper = 0, m_fpw = 0;
  logic [2:0]  m_lvl = '0;

  always #10 clk = ~clk;

  pwm_dbuf dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .reg_sel_i(sel),
    .wr_i(wr), .rd_i(rd), .wdata_i(wd), .rdata_o(rdata),
    .irq_o(irq), .irq_lvl_o(irq_lvl), .pwm_o(pwm)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected post-edge state
  task automatic step(input bit e, input logic [1:0] s, input bit w, input bit r,
                      input logic [15:0] d, input string tag);
    bit ld, set;
    logic p;
    item_t it;
    @(negedge clk);
    en = e; sel = s; wr = w; rd = r; wd = d;
    ld = e && w && s == 2'd0 && d[5];
    set = 0;
    if (!e) begin
      m_run = 0; m_p = 0; m_fl = 0; m_arm = 0;
    end else begin
      if (!m_run || ld) begin
        m_run = 1; m_cper = m_fper; m_cpw = m_fpw; m_p = 0; set = 1;
      end else if (m_p == m_cper - 1) begin
        m_cper = m_fper; m_cpw = m_fpw; m_p = 0; set = 1;
      end else m_p++;
      if (set) begin m_fl = 1; m_arm = 0; end
      else if (w && s == 2'd0) begin
        if (m_arm && !d[15]) m_fl = 0;
        m_arm = 0;
      end else if (r && s == 2'd0) m_arm = m_fl;
    end
    if (w) begin
      if (s == 2'd1) m_fper = int'(d);
      if (s == 2'd2) m_fpw = int'(d);
      if (s == 2'd0) m_lvl = d[14:12];
    end
    p = m_run && m_cpw != 0 && m_p < m_cpw;
    it.pwm = p;
    it.irq = m_fl && m_lvl != 0;
    it.lvl = it.irq ? m_lvl : 3'd0;
    case (s)
      2'd0: it.rdata = {m_fl, m_lvl, 4'b0, p, 7'b0};
      2'd1: it.rdata = 16'(m_fper);
      2'd2: it.rdata = 16'(m_fpw);
      default: it.rdata = '0;
    endcase
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(en, 2'd0, 0, 0, 16'h0, tag);
  endtask

  task automatic wait_phase(input int t, input string tag);
    for (int i = 0; i < 70000 && m_p != t; i++) step(1, 2'd0, 0, 0, 16'h0, tag);
  endtask

  // monitor: compares after each edge, away from it
  always @(posedge clk) begin
    #3;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk({it.tag, " pwm_o"}, {15'b0, pwm}, {15'b0, it.pwm});
      chk({it.tag, " irq_o"}, {15'b0, irq}, {15'b0, it.irq});
      chk({it.tag, " irq_lvl_o"}, {13'b0, irq_lvl}, {13'b0, it.lvl});
      chk({it.tag, " rdata_o"}, rdata, it.rdata);
    end
  end

  initial begin
    #(20ns * 200000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #5;
    chk("R1 reset pwm_o", {15'b0, pwm}, 16'h0);
    chk("R1 reset irq_o", {15'b0, irq}, 16'h0);
    chk("R1 reset rdata_o", rdata, 16'h0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    step(0, 2'd0, 0, 0, 16'h0, "R1");
    step(0, 2'd1, 0, 0, 16'h0, "R1");
    step(0, 2'd2, 0, 0, 16'h0, "R1");
    // R2 register access
    step(0, 2'd1, 1, 0, 16'd10, "R2");
    step(0, 2'd2, 1, 0, 16'd3, "R2");
    step(0, 2'd0, 1, 0, 16'h3000, "R2");
    step(0, 2'd1, 0, 0, 16'h0, "R2");
    step(0, 2'd2, 0, 0, 16'h0, "R2");
    step(0, 2'd3, 0, 0, 16'h0, "R2");
    step(0, 2'd0, 0, 0, 16'h0, "R2");
    // R9 load and flag write while disabled
    step(0, 2'd0, 1, 0, 16'hB020, "R9");
    step(0, 2'd0, 0, 0, 16'h0, "R9");
    // R3 enable
    step(1, 2'd0, 0, 0, 16'h0, "R3");
    idle(24, "R4");
    idle(12, "R6");
    // R7 clear handshake
    wait_phase(2, "R6");
    step(1, 2'd0, 0, 1, 16'h0, "R7");
    step(1, 2'd0, 1, 0, 16'h3000, "R7");
    step(1, 2'd0, 1, 0, 16'hB000, "R7");
    idle(2, "R7");
    wait_phase(1, "R7");
    step(1, 2'd0, 1, 0, 16'h3000, "R7");
    step(1, 2'd0, 0, 1, 16'h0, "R7");
    step(1, 2'd0, 1, 0, 16'hB000, "R7");
    // R8 cancelled clear: read, boundary, zero write
    wait_phase(8, "R8");
    step(1, 2'd0, 0, 1, 16'h0, "R8");
    step(1, 2'd0, 0, 0, 16'h0, "R8");
    step(1, 2'd0, 1, 0, 16'h3000, "R8");
    idle(2, "R8");
    // R5 double buffer
    wait_phase(1, "R5");
    step(1, 2'd2, 1, 0, 16'd7, "R5");
    idle(22, "R5");
    // R12 pin bit read-only
    step(1, 2'd0, 1, 0, 16'h3080, "R12");
    idle(12, "R12");
    // R10 load command mid-period
    step(1, 2'd1, 1, 0, 16'd6, "R10");
    step(1, 2'd2, 1, 0, 16'd2, "R10");
    wait_phase(4, "R10");
    step(1, 2'd0, 1, 0, 16'h3020, "R10");
    idle(14, "R10");
    // R4 corner pulses
    step(1, 2'd2, 1, 0, 16'd0, "R4");
    step(1, 2'd0, 1, 0, 16'h3020, "R4");
    idle(8, "R4");
    step(1, 2'd2, 1, 0, 16'd9, "R4");
    step(1, 2'd0, 1, 0, 16'h3020, "R4");
    idle(14, "R4");
    step(1, 2'd2, 1, 0, 16'd6, "R4");
    idle(14, "R4");
    step(1, 2'd1, 1, 0, 16'd1, "R4");
    step(1, 2'd2, 1, 0, 16'd0, "R4");
    idle(6, "R4");
    step(1, 2'd1, 1, 0, 16'd5, "R4");
    step(1, 2'd2, 1, 0, 16'd1, "R4");
    idle(12, "R4");
    // R11 levels
    step(1, 2'd0, 1, 0, 16'h0000, "R11");
    idle(4, "R11");
    step(1, 2'd0, 1, 0, 16'h7000, "R11");
    idle(4, "R11");
    // R9 disable then R3 re-enable
    step(0, 2'd0, 0, 0, 16'h0, "R9");
    step(0, 2'd0, 1, 0, 16'h7020, "R9");
    idle(5, "R9");
    step(1, 2'd0, 0, 0, 16'h0, "R3");
    idle(8, "R3");
    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule